// File: doc/BRIEF.md
# Bidirectional Port Register Block with Pulse-Output Handover

This block holds the per-pin state of one general-purpose I/O port on a microcontroller's register bus. A direction register decides, bit by bit, whether the pin is driven by the chip or only observed. A data register holds the values driven onto output pins. Pin levels are passed through a synchronizer before they are read. A read of the data address returns a mix: latched data on output bits and synchronized pin level on input bits.

Any data bit can be handed to a timed pulse-output unit. A bit set in the next-data enable mask is then protected from CPU writes. It changes only when the pulse unit raises its load strobe, which copies the matching bit of the next-data input. Bits outside the mask stay under CPU control, including in the cycle of a load.

Two standby inputs are provided. Hardware standby clears the port. Software standby freezes it, and the output pins keep driving their last values.

Top module: `gpio_pulse_port`

## Requirements
- R1: After reset (`rst_n` low) both registers are zero, so `pin_oe` and `pin_out` are all zero and a data read returns the synchronized pin level.
- R2: A write with `reg_sel`=0 loads the direction register from `wdata` at the clock edge. `pin_oe` bit i is 1 (output) exactly when direction bit i is 1.
- R3: A read with `reg_sel`=0 returns all ones, whatever the direction register holds.
- R4: A read with `reg_sel`=1 returns, for each bit, the data register bit if its direction bit is 1, and otherwise the synchronized pin level.
- R5: A change on `pin_in` becomes visible in a data read after exactly two rising clock edges.
- R6: A CPU data write (`reg_sel`=1) leaves unchanged every data bit whose `nd_mask` bit is 1.
- R7: A cycle with `nd_load` high loads each data bit whose `nd_mask` bit is 1 from `nd_data`, and leaves the other data bits unchanged.
- R8: When a CPU data write and `nd_load` fall in the same cycle, masked bits take `nd_data` and unmasked bits take `wdata`.
- R9: While `sw_stby` is high (and `hw_stby` low), both registers hold their values, CPU writes and load strobes are ignored, and `pin_out`/`pin_oe` keep their values.
- R10: While `hw_stby` is high, both registers clear to zero at every clock edge, overriding writes, load strobes and `sw_stby`.
- R11: `rdata` is zero whenever `rd_en` is low.
- R12: `pin_out` always equals the data register, including on bits configured as inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_stby | input | 1 | Hardware standby: clears the registers |
| sw_stby | input | 1 | Software standby: freezes the registers |
| reg_sel | input | 1 | Register select: 0 = direction, 1 = data |
| wr_en | input | 1 | Bus write enable |
| rd_en | input | 1 | Bus read enable |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data, valid in the same cycle |
| nd_mask | input | 8 | Next-data enable mask: 1 hands the bit to the pulse unit |
| nd_data | input | 8 | Next-data value from the pulse unit |
| nd_load | input | 1 | Next-data transfer strobe |
| pin_in | input | 8 | Pin levels, asynchronous |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |

## Verification
Reads are combinational, so a read result is due in the same cycle as its request. It reflects the register state left by the previous edge. Writes, load strobes and standby take effect at the next edge, and a pin change reaches the read path two edges later. The driver applies each stimulus just after a falling edge. Before the rising edge it queues the result the requirements predict for that cycle, and only then advances its own register and synchronizer model. The monitor samples one nanosecond later, still before the rising edge, and compares against the head of the queue. Each expectation is therefore tied to the edge count the requirements give.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;

   typedef enum logic {
      REG_DIR  = 1'b0,
      REG_DATA = 1'b1
   } port_reg_e;

   // Overlay new bits onto old bits wherever sel is set
   function automatic logic [63:0] overlay(input logic [63:0] old_v,
                                           input logic [63:0] new_v,
                                           input logic [63:0] sel);
      return (old_v & ~sel) | (new_v & sel);
   endfunction

endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   logic [WIDTH-1:0] stage_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_dir_reg.sv
`timescale 1ns/1ps
module gpio_dir_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             freeze,
   input  logic             wr_hit,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] dir_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                dir_q <= '0;
      else if (clear)            dir_q <= '0;
      else if (!freeze && wr_hit) dir_q <= wdata;
   end

endmodule

// File: rtl/gpio_data_reg.sv
`timescale 1ns/1ps
module gpio_data_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             freeze,
   input  logic             wr_hit,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] nd_mask,
   input  logic [WIDTH-1:0] nd_data,
   input  logic             nd_load,
   output logic [WIDTH-1:0] data_q
);

   logic [WIDTH-1:0] cpu_bits;
   logic [WIDTH-1:0] next_bits;

   // Per-bit selection: a masked bit listens only to the transfer strobe
   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_bit
         always_comb begin
            cpu_bits[b] = (wr_hit && !nd_mask[b]) ? wdata[b] : data_q[b];
            if (nd_load && nd_mask[b]) next_bits[b] = nd_data[b];
            else                       next_bits[b] = cpu_bits[b];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_q <= '0;
      else if (clear)   data_q <= '0;
      else if (!freeze) data_q <= next_bits;
   end

endmodule

// File: rtl/gpio_rd_mux.sv
`timescale 1ns/1ps
module gpio_rd_mux #(
   parameter int WIDTH = 8
) (
   input  logic             rd_en,
   input  gpio_pkg::port_reg_e sel,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] data_q,
   input  logic [WIDTH-1:0] pin_sync,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] port_view;

   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_view
         assign port_view[b] = dir_q[b] ? data_q[b] : pin_sync[b];
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         unique case (sel)
            gpio_pkg::REG_DIR:  rdata = '1;
            gpio_pkg::REG_DATA: rdata = port_view;
         endcase
      end
   end

endmodule

// File: rtl/gpio_pulse_port.sv
`timescale 1ns/1ps
module gpio_pulse_port #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_stby,
   input  logic             sw_stby,
   input  logic             reg_sel,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata,
   input  logic [WIDTH-1:0] nd_mask,
   input  logic [WIDTH-1:0] nd_data,
   input  logic             nd_load,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe
);
   import gpio_pkg::*;

   localparam int MaxWidth = 64;

   generate
      if (WIDTH < 1 || WIDTH > MaxWidth) begin : g_bad_width
         $error("gpio_pulse_port: WIDTH out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_pulse_port: SYNC_STAGES below 2");
      end
   endgenerate

   port_reg_e        sel;
   logic             freeze;
   logic             dir_hit;
   logic             data_hit;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] data_q;
   logic [WIDTH-1:0] pin_sync;

   assign sel      = port_reg_e'(reg_sel);
   assign freeze   = sw_stby && !hw_stby;
   assign dir_hit  = wr_en && (sel == REG_DIR);
   assign data_hit = wr_en && (sel == REG_DATA);

   gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (pin_sync)
   );

   gpio_dir_reg #(.WIDTH(WIDTH)) u_dir (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (hw_stby),
      .freeze (freeze),
      .wr_hit (dir_hit),
      .wdata  (wdata),
      .dir_q  (dir_q)
   );

   gpio_data_reg #(.WIDTH(WIDTH)) u_data (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (hw_stby),
      .freeze  (freeze),
      .wr_hit  (data_hit),
      .wdata   (wdata),
      .nd_mask (nd_mask),
      .nd_data (nd_data),
      .nd_load (nd_load),
      .data_q  (data_q)
   );

   gpio_rd_mux #(.WIDTH(WIDTH)) u_rd (
      .rd_en    (rd_en),
      .sel      (sel),
      .dir_q    (dir_q),
      .data_q   (data_q),
      .pin_sync (pin_sync),
      .rdata    (rdata)
   );

   assign pin_oe  = dir_q;
   assign pin_out = data_q;

endmodule

// File: rtl/gpio_pulse_port_chk.sv
`timescale 1ns/1ps
module gpio_pulse_port_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hw_stby,
   input logic             sw_stby,
   input logic             reg_sel,
   input logic             wr_en,
   input logic             rd_en,
   input logic [WIDTH-1:0] wdata,
   input logic [WIDTH-1:0] rdata,
   input logic [WIDTH-1:0] nd_mask,
   input logic [WIDTH-1:0] nd_data,
   input logic             nd_load,
   input logic [WIDTH-1:0] pin_out,
   input logic [WIDTH-1:0] pin_oe
);

   p_dir_reads_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !reg_sel) |-> (rdata == '1));

   p_idle_bus_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rdata == '0));

   p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !reg_sel && !hw_stby && !sw_stby) |=> (pin_oe == $past(wdata)));

   p_masked_protect_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!hw_stby && !nd_load) |=> (((pin_out ^ $past(pin_out)) & $past(nd_mask)) == '0));

   p_load_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (nd_load && !hw_stby && !sw_stby) |=>
         ((pin_out & $past(nd_mask)) == ($past(nd_data) & $past(nd_mask))));

   p_sw_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_stby && !hw_stby) |=> ($stable(pin_out) && $stable(pin_oe)));

   p_hw_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hw_stby |=> (pin_out == '0 && pin_oe == '0));

endmodule

bind gpio_pulse_port gpio_pulse_port_chk #(.WIDTH(WIDTH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .hw_stby (hw_stby),
   .sw_stby (sw_stby),
   .reg_sel (reg_sel),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .wdata   (wdata),
   .rdata   (rdata),
   .nd_mask (nd_mask),
   .nd_data (nd_data),
   .nd_load (nd_load),
   .pin_out (pin_out),
   .pin_oe  (pin_oe)
);

// File: tb/sim_gpio_pulse_port.sv
`timescale 1ns/1ps
module sim_gpio_pulse_port;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         hw_stby = 1'b0, sw_stby = 1'b0;
   logic         reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [W-1:0] wdata = '0, nd_mask = '0, nd_data = '0, pin_in = '0;
   logic         nd_load = 1'b0;
   logic [W-1:0] rdata, pin_out, pin_oe;

   always #2 clk = ~clk;   // 250 MHz

   gpio_pulse_port #(.WIDTH(W), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
      .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
      .rdata(rdata), .nd_mask(nd_mask), .nd_data(nd_data), .nd_load(nd_load),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   typedef struct {
      logic [W-1:0] rd;
      logic [W-1:0] out;
      logic [W-1:0] oe;
      string        tag;
   } exp_t;

   exp_t queue_q[$];
   int   n_vec = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   // Bench model of the requirements
   logic [W-1:0] m_dir = '0, m_dat = '0, m_s1 = '0, m_s2 = '0;

   task automatic step(input logic sel, input logic we, input logic re,
                       input logic [W-1:0] wd, input logic [W-1:0] msk,
                       input logic [W-1:0] nd, input logic ld,
                       input logic [W-1:0] pin, input logic sw, input logic hw,
                       input string tag);
      exp_t e;
      logic [W-1:0] nxt;
      @(negedge clk);
      #0.5;
      reg_sel = sel; wr_en = we; rd_en = re; wdata = wd; nd_mask = msk;
      nd_data = nd; nd_load = ld; pin_in = pin; sw_stby = sw; hw_stby = hw;
      // R3, R4, R11: same-cycle read value from current state
      if (!re)       e.rd = '0;
      else if (!sel) e.rd = '1;
      else           e.rd = (m_dat & m_dir) | (m_s2 & ~m_dir);
      e.out = m_dat;   // R12
      e.oe  = m_dir;   // R2
      e.tag = tag;
      queue_q.push_back(e);
      // state after the coming rising edge
      if (hw) begin
         m_dir = '0; m_dat = '0;                     // R10
      end else if (!sw) begin                        // R9 otherwise holds
         if (we && !sel) m_dir = wd;
         nxt = m_dat;
         if (we && sel) nxt = (wd & ~msk) | (m_dat & msk);   // R6
         if (ld)        nxt = (nxt & ~msk) | (nd & msk);     // R7, R8
         m_dat = nxt;
      end
      m_s2 = m_s1;                                   // R5
      m_s1 = pin;
   endtask

   // Monitor: pop and compare before the rising edge
   initial begin
      forever begin
         @(negedge clk);
         #1.5;
         if (queue_q.size() > 0) begin
            exp_t e;
            e = queue_q.pop_front();
            n_vec++;
            if (rdata !== e.rd || pin_out !== e.out || pin_oe !== e.oe) begin
               n_bad++;
               $display("FAIL %s: rdata=%h out=%h oe=%h expected rdata=%h out=%h oe=%h",
                        e.tag, rdata, pin_out, pin_oe, e.rd, e.out, e.oe);
            end
         end
      end
   end

   initial begin
      #100000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      step(1, 0, 1, 8'h00, 8'h00, 8'h00, 0, 8'h00, 0, 0, "R1 reset");
      step(1, 0, 1, 8'h00, 8'h00, 8'h00, 0, 8'h00, 0, 0, "R1 reset read");
      // R3: direction read is all ones
      step(0, 0, 1, 8'h00, 8'h00, 8'h00, 0, 8'h00, 0, 0, "R3 dir read");
      // R2: direction write
      step(0, 1, 0, 8'hF0, 8'h00, 8'h00, 0, 8'h00, 0, 0, "R2 dir write");
      step(0, 0, 1, 8'h00, 8'h00, 8'h00, 0, 8'h00, 0, 0, "R2 R3 oe and dir read");
      // R4/R12: data write, pins change
      step(1, 1, 1, 8'hA5, 8'h00, 8'h00, 0, 8'h3C, 0, 0, "R12 data write");
      step(1, 0, 1, 8'h00, 8'h00, 8'h00, 0, 8'h3C, 0, 0, "R5 one edge");
      step(1, 0, 1, 8'h00, 8'h00, 8'h00, 0, 8'h3C, 0, 0, "R4 R5 two edges");
      step(1, 0, 0, 8'h00, 8'h00, 8'h00, 0, 8'h3C, 0, 0, "R11 idle read");
      // R6: masked bits ignore CPU writes
      step(1, 1, 1, 8'hFF, 8'h0F, 8'h00, 0, 8'h3C, 0, 0, "R6 masked write");
      step(1, 0, 1, 8'h00, 8'h0F, 8'h00, 0, 8'h3C, 0, 0, "R6 after write");
      // R7: transfer strobe
      step(1, 0, 1, 8'h00, 8'h0F, 8'h09, 1, 8'h3C, 0, 0, "R7 load");
      step(1, 0, 1, 8'h00, 8'h0F, 8'h00, 0, 8'h3C, 0, 0, "R7 after load");
      // R8: collision
      step(1, 1, 1, 8'h00, 8'h0F, 8'h06, 1, 8'h3C, 0, 0, "R8 collision");
      step(1, 0, 1, 8'h00, 8'h0F, 8'h00, 0, 8'h3C, 0, 0, "R8 after collision");
      // R12: direction input, output still data
      step(0, 1, 0, 8'h00, 8'h00, 8'h00, 0, 8'h3C, 0, 0, "R12 dir clear");
      step(1, 0, 1, 8'h00, 8'h00, 8'h00, 0, 8'hC3, 0, 0, "R12 out with inputs");
      step(0, 1, 0, 8'hFF, 8'h00, 8'h00, 0, 8'hC3, 0, 0, "R2 dir all out");
      // R9: software standby
      step(1, 1, 1, 8'h12, 8'h00, 8'h00, 0, 8'hC3, 1, 0, "R9 sw write");
      step(1, 0, 1, 8'h00, 8'hFF, 8'h77, 1, 8'hC3, 1, 0, "R9 sw load");
      step(0, 1, 1, 8'h00, 8'h00, 8'h00, 0, 8'hC3, 1, 0, "R9 sw dir write");
      step(1, 0, 1, 8'h00, 8'h00, 8'h00, 0, 8'hC3, 0, 0, "R9 after sw");
      // R10: hardware standby
      step(1, 1, 1, 8'h5A, 8'h00, 8'h00, 1, 8'hC3, 1, 1, "R10 hw with write");
      step(0, 1, 0, 8'h5A, 8'h00, 8'h00, 0, 8'hC3, 0, 1, "R10 hw dir write");
      step(1, 0, 1, 8'h00, 8'h00, 8'h00, 0, 8'hC3, 0, 0, "R10 cleared");
      // Mixed patterns
      for (int i = 0; i < 60; i++) begin
         logic [W-1:0] a, b, c, d;
         a = W'(i * 37 + 11);
         b = W'(i * 91 + 5);
         c = W'(i * 53 ^ 8'h6B);
         d = W'(i * 29 + 200);
         step(a[0], b[1], 1, c, b, d, (i % 3) == 0, a, (i % 11) == 7,
              (i % 17) == 16, "R4 R7 R8 mixed");
      end
      step(1, 0, 1, 8'h00, 8'h00, 8'h00, 0, 8'h00, 0, 0, "R4 final");
      step(1, 0, 1, 8'h00, 8'h00, 8'h00, 0, 8'h00, 0, 0, "R4 final");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule